// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block sits between one core's load/store port and that core's private L1 data port. A store is finished, as far as the core is concerned, as soon as the queue takes it. The queue then writes its entries to the L1 in the order they arrived, one entry per cycle, using a valid/ready handshake. Because an accepted store can wait in the queue while later loads go ahead, other cores can see a store followed by a load to another address in the opposite order. This is the usual total-store-order relaxation.

Every load searches the queue first. If one or more queued stores have the load's address, the most recently accepted of them supplies the data. If none match, the block reads the L1 in the same cycle. Either way the answer comes back one cycle after the load is accepted, together with a flag that says which source supplied it. A fence request holds the core's load and store ports closed and completes only when the queue is empty. This one mechanism gives every ordering guarantee the core may ask for.

Top module: `stq_top`

## Requirements
- R1: After reset the queue is empty: `l1w_valid` is 0, `fence_ready` is 1, `st_ready` is 1 and `ld_rsp_valid` is 0.
- R2: A store is taken in a cycle where `st_valid` and `st_ready` are both 1. `st_ready` is 0 whenever the queue holds DEPTH entries or `fence_valid` is 1. An entry leaving the queue in the same cycle does not raise `st_ready`.
- R3: The L1 write port always shows the oldest queued entry. While `l1w_valid` is 1 and `l1w_ready` is 0, `l1w_addr` and `l1w_data` hold their values.
- R4: `l1w_valid` is 1 exactly when the queue is not empty. One entry leaves in each cycle with `l1w_valid` and `l1w_ready` both 1, and entries leave in the order they were accepted.
- R5: A load whose address matches one or more queued entries returns the data of the most recently accepted match, with `ld_rsp_fwd` = 1. No L1 read is issued for it (`l1r_en` stays 0).
- R6: A load that matches no queued entry raises `l1r_en`, with `l1r_addr` equal to the load address, in its acceptance cycle. It returns the `l1r_data` seen in that cycle, with `ld_rsp_fwd` = 0. It does not wait for older stores to other addresses to leave the queue.
- R7: `ld_rsp_valid` is 1 in the cycle after a load is accepted (`ld_valid` and `ld_ready` both 1) and 0 in every other cycle.
- R8: A load accepted in the same cycle as a store does not see that store. An entry that leaves the queue in the load's acceptance cycle is still searched.
- R9: While `fence_valid` is 1, `ld_ready` and `st_ready` are 0. `fence_ready` is 1 exactly when the queue is empty, and the fence completes in a cycle where both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Core presents a store |
| st_ready | output | 1 | Queue can take the store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Core presents a load |
| ld_ready | output | 1 | Load can be accepted |
| ld_addr | input | ADDR_W | Load address |
| ld_rsp_valid | output | 1 | Load result valid |
| ld_rsp_data | output | DATA_W | Load result data |
| ld_rsp_fwd | output | 1 | 1 if the result came from the queue |
| fence_valid | input | 1 | Core requests a fence |
| fence_ready | output | 1 | Queue empty; fence completes |
| l1w_valid | output | 1 | Write to L1 offered |
| l1w_ready | input | 1 | L1 accepts the write |
| l1w_addr | output | ADDR_W | Write address to L1 |
| l1w_data | output | DATA_W | Write data to L1 |
| l1r_en | output | 1 | Read L1 this cycle |
| l1r_addr | output | ADDR_W | Read address to L1 |
| l1r_data | input | DATA_W | L1 read data, same cycle |

## Verification
The hardest case to reach is a load that arrives while several queued entries share its address, the L1 write port is stalled, and the matching entries have wrapped around the end of the ring storage. Only the youngest of them may answer. The stimulus first fills the queue with the L1 port held not-ready, repeating an address so that it is buffered twice. It then probes that address, and finally runs a long random mix over only eight addresses with bursty write-ready and occasional fences. That mix carries the head pointer around the ring many times while same-address stores and loads collide, including stores and loads in the same cycle. A behavioural queue in the bench predicts every port value each cycle.

// File: rtl/stq_pkg.sv
`timescale 1ns/1ps
package stq_pkg;
   // Source of the load result returned in the next cycle
   typedef enum logic [1:0] {
      SRC_IDLE   = 2'd0,
      SRC_BUFFER = 2'd1,
      SRC_CACHE  = 2'd2
   } ld_src_e;

   // Bits needed to index n slots
   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // Bits needed to count 0..n
   function automatic int cnt_bits(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/stq_ring.sv
`timescale 1ns/1ps
// Circular storage for queued stores: allocation at the tail, removal at the head.
module stq_ring
   import stq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int PTR_W  = idx_bits(DEPTH),
   parameter int CNT_W  = cnt_bits(DEPTH)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [ADDR_W-1:0]              push_addr,
   input  logic [DATA_W-1:0]              push_data,
   input  logic                           pop,
   output logic                           full,
   output logic                           empty,
   output logic [PTR_W-1:0]               head_idx,
   output logic [DEPTH-1:0]               slot_valid,
   output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
   output logic [DEPTH-1:0][DATA_W-1:0]   slot_data,
   output logic [ADDR_W-1:0]              head_addr,
   output logic [DATA_W-1:0]              head_data
);
   logic [PTR_W-1:0]             head_q, tail_q;
   logic [CNT_W-1:0]             cnt_q;
   logic [DEPTH-1:0]             vld_q;
   logic [DEPTH-1:0][ADDR_W-1:0] adr_q;
   logic [DEPTH-1:0][DATA_W-1:0] dat_q;
   logic                         do_push, do_pop;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push & ~full;    // R2: never write past DEPTH entries
   assign do_pop  = pop & ~empty;    // R4: one entry per cycle at most

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) tail_q <= bump(tail_q);
         if (do_pop)  head_q <= bump(head_q);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // Occupancy flags per slot; push and pop never hit the same slot in one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (do_push && tail_q == PTR_W'(i))
               vld_q[i] <= 1'b1;
            else if (do_pop && head_q == PTR_W'(i))
               vld_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         adr_q[tail_q] <= push_addr;
         dat_q[tail_q] <= push_data;
      end
   end

   assign head_idx   = head_q;
   assign slot_valid = vld_q;
   assign slot_addr  = adr_q;
   assign slot_data  = dat_q;
   assign head_addr  = adr_q[head_q];   // R3: oldest entry faces the L1
   assign head_data  = dat_q[head_q];
endmodule

// File: rtl/stq_seek.sv
`timescale 1ns/1ps
// Address search over the queue; returns the youngest matching entry.
module stq_seek
   import stq_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int PTR_W      = idx_bits(DEPTH),
   parameter bit ONEHOT_SEL = 1'b0
) (
   input  logic [PTR_W-1:0]             head_idx,
   input  logic [DEPTH-1:0]             slot_valid,
   input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
   input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
   input  logic [ADDR_W-1:0]            probe_addr,
   output logic                         hit,
   output logic [DATA_W-1:0]            hit_data
);
   logic [DEPTH-1:0] eq;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign eq[i] = slot_valid[i] && (slot_addr[i] == probe_addr);
   end

   assign hit = |eq;

   // Distance of a slot from the head: larger means more recently accepted
   function automatic int slot_age(input int slot, input int head);
      int a;
      a = slot - head;
      if (a < 0) a = a + DEPTH;
      return a;
   endfunction

   if (ONEHOT_SEL) begin : g_onehot
      // Parallel variant: one-hot select of the youngest match, then AND-OR mux
      logic [DEPTH-1:0] pick;
      always_comb begin
         for (int i = 0; i < DEPTH; i++) begin
            pick[i] = eq[i];
            for (int j = 0; j < DEPTH; j++) begin
               if (j != i && eq[j] &&
                   slot_age(j, int'(head_idx)) > slot_age(i, int'(head_idx)))
                  pick[i] = 1'b0;
            end
         end
      end
      always_comb begin
         hit_data = '0;
         for (int i = 0; i < DEPTH; i++)
            if (pick[i]) hit_data = hit_data | slot_data[i];
      end
   end else begin : g_scan
      // Serial variant: walk from oldest to youngest, last match wins (R5)
      always_comb begin
         int j;
         hit_data = '0;
         for (int k = 0; k < DEPTH; k++) begin
            j = int'(head_idx) + k;
            if (j >= DEPTH) j = j - DEPTH;
            if (eq[j]) hit_data = slot_data[j];
         end
      end
   end
endmodule

// File: rtl/stq_ldrsp.sv
`timescale 1ns/1ps
// Load result register: chooses queue or L1 data, returns it one cycle later.
module stq_ldrsp
   import stq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_fire,
   input  logic              buf_hit,
   input  logic [DATA_W-1:0] buf_data,
   input  logic [DATA_W-1:0] cache_data,
   output logic              cache_rd,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_fwd
);
   ld_src_e           src_d, src_q;
   logic [DATA_W-1:0] dat_q;

   always_comb begin
      if (!ld_fire)     src_d = SRC_IDLE;
      else if (buf_hit) src_d = SRC_BUFFER;
      else              src_d = SRC_CACHE;
   end

   assign cache_rd = (src_d == SRC_CACHE);   // R6: read L1 only on a miss

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= SRC_IDLE;
      else        src_q <= src_d;
   end

   always_ff @(posedge clk) begin
      if (ld_fire) dat_q <= buf_hit ? buf_data : cache_data;
   end

   assign rsp_valid = (src_q != SRC_IDLE);   // R7
   assign rsp_fwd   = (src_q == SRC_BUFFER);
   assign rsp_data  = dat_q;
endmodule

// File: rtl/stq_top.sv
`timescale 1ns/1ps
// Per-core store queue with in-order drain, youngest-match forwarding and fence stall.
module stq_top
   import stq_pkg::*;
#(
   parameter int DEPTH      = 8,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter bit ONEHOT_SEL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              ld_valid,
   output logic              ld_ready,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_rsp_valid,
   output logic [DATA_W-1:0] ld_rsp_data,
   output logic              ld_rsp_fwd,
   input  logic              fence_valid,
   output logic              fence_ready,
   output logic              l1w_valid,
   input  logic              l1w_ready,
   output logic [ADDR_W-1:0] l1w_addr,
   output logic [DATA_W-1:0] l1w_data,
   output logic              l1r_en,
   output logic [ADDR_W-1:0] l1r_addr,
   input  logic [DATA_W-1:0] l1r_data
);
   localparam int PTR_W = idx_bits(DEPTH);
   localparam int CNT_W = cnt_bits(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("stq_top: DEPTH must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("stq_top: ADDR_W and DATA_W must be positive");
   end

   logic                         q_full, q_empty;
   logic [PTR_W-1:0]             q_head;
   logic [DEPTH-1:0]             q_vld;
   logic [DEPTH-1:0][ADDR_W-1:0] q_adr;
   logic [DEPTH-1:0][DATA_W-1:0] q_dat;
   logic                         st_fire, ld_fire, drain;
   logic                         fwd_hit;
   logic [DATA_W-1:0]            fwd_data;

   // R9: a pending fence closes both core ports
   assign st_ready    = ~q_full & ~fence_valid;   // R2
   assign ld_ready    = ~fence_valid;
   assign fence_ready = q_empty;
   assign st_fire     = st_valid & st_ready;
   assign ld_fire     = ld_valid & ld_ready;

   assign l1w_valid   = ~q_empty;                 // R4
   assign drain       = l1w_valid & l1w_ready;

   stq_ring #(
      .DEPTH (DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PTR_W (PTR_W), .CNT_W (CNT_W)
   ) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (st_fire),
      .push_addr  (st_addr),
      .push_data  (st_data),
      .pop        (drain),
      .full       (q_full),
      .empty      (q_empty),
      .head_idx   (q_head),
      .slot_valid (q_vld),
      .slot_addr  (q_adr),
      .slot_data  (q_dat),
      .head_addr  (l1w_addr),
      .head_data  (l1w_data)
   );

   // R8: search uses state before this cycle's push and pop take effect
   stq_seek #(
      .DEPTH (DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PTR_W (PTR_W), .ONEHOT_SEL(ONEHOT_SEL)
   ) u_seek (
      .head_idx   (q_head),
      .slot_valid (q_vld),
      .slot_addr  (q_adr),
      .slot_data  (q_dat),
      .probe_addr (ld_addr),
      .hit        (fwd_hit),
      .hit_data   (fwd_data)
   );

   stq_ldrsp #(.DATA_W(DATA_W)) u_ldrsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_fire    (ld_fire),
      .buf_hit    (fwd_hit),
      .buf_data   (fwd_data),
      .cache_data (l1r_data),
      .cache_rd   (l1r_en),
      .rsp_valid  (ld_rsp_valid),
      .rsp_data   (ld_rsp_data),
      .rsp_fwd    (ld_rsp_fwd)
   );

   assign l1r_addr = ld_addr;
endmodule

// File: rtl/stq_checker.sv
`timescale 1ns/1ps
module stq_checker
   import stq_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_valid,
   input logic              st_ready,
   input logic              ld_valid,
   input logic              ld_ready,
   input logic [ADDR_W-1:0] ld_addr,
   input logic              ld_rsp_valid,
   input logic              ld_rsp_fwd,
   input logic              fence_valid,
   input logic              fence_ready,
   input logic              l1w_valid,
   input logic              l1w_ready,
   input logic [ADDR_W-1:0] l1w_addr,
   input logic [DATA_W-1:0] l1w_data,
   input logic              l1r_en,
   input logic [ADDR_W-1:0] l1r_addr
);
   localparam int CNT_W = cnt_bits(DEPTH);

   // Shadow occupancy built only from port handshakes
   logic [CNT_W-1:0] occ;
   logic             in_hs, out_hs;
   assign in_hs  = st_valid & st_ready;
   assign out_hs = l1w_valid & l1w_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else if (in_hs && !out_hs) occ <= occ + 1'b1;
      else if (!in_hs && out_hs) occ <= occ - 1'b1;
   end

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == CNT_W'(DEPTH)) |-> !st_ready);

   p_drain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (l1w_valid && !l1w_ready) |=> (l1w_valid && $stable(l1w_addr) && $stable(l1w_data)));

   p_drain_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
      l1w_valid == (occ != '0));

   p_hit_forwards_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_ready && !l1r_en) |=> (ld_rsp_valid && ld_rsp_fwd));

   p_miss_reads_l1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      l1r_en |-> (ld_valid && ld_ready && l1r_addr == ld_addr));

   p_miss_not_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      l1r_en |=> (ld_rsp_valid && !ld_rsp_fwd));

   p_rsp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_valid && ld_ready) |=> !ld_rsp_valid);

   p_fence_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fence_valid |-> (!ld_ready && !st_ready));

   p_fence_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fence_ready == (occ == '0));
endmodule

bind stq_top stq_checker #(
   .DEPTH (DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_stq_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st_valid     (st_valid),
   .st_ready     (st_ready),
   .ld_valid     (ld_valid),
   .ld_ready     (ld_ready),
   .ld_addr      (ld_addr),
   .ld_rsp_valid (ld_rsp_valid),
   .ld_rsp_fwd   (ld_rsp_fwd),
   .fence_valid  (fence_valid),
   .fence_ready  (fence_ready),
   .l1w_valid    (l1w_valid),
   .l1w_ready    (l1w_ready),
   .l1w_addr     (l1w_addr),
   .l1w_data     (l1w_data),
   .l1r_en       (l1r_en),
   .l1r_addr     (l1r_addr)
);

// File: tb/stq_top_tb.sv
`timescale 1ns/1ps
module stq_top_tb;
   localparam int DEPTH = 4;
   localparam int AW    = 4;
   localparam int DW    = 16;
   localparam int EW    = AW + DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0, st_ready;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          ld_valid = 1'b0, ld_ready;
   logic [AW-1:0] ld_addr = '0;
   logic          ld_rsp_valid, ld_rsp_fwd;
   logic [DW-1:0] ld_rsp_data;
   logic          fence_valid = 1'b0, fence_ready;
   logic          l1w_valid, l1w_ready = 1'b0;
   logic [AW-1:0] l1w_addr;
   logic [DW-1:0] l1w_data;
   logic          l1r_en;
   logic [AW-1:0] l1r_addr;
   logic [DW-1:0] l1r_data;

   always #2.5 clk = ~clk;   // 200 MHz

   stq_top #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
      .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data), .ld_rsp_fwd(ld_rsp_fwd),
      .fence_valid(fence_valid), .fence_ready(fence_ready),
      .l1w_valid(l1w_valid), .l1w_ready(l1w_ready), .l1w_addr(l1w_addr), .l1w_data(l1w_data),
      .l1r_en(l1r_en), .l1r_addr(l1r_addr), .l1r_data(l1r_data)
   );

   // L1 data array driven by the queue's writes
   logic [DW-1:0] l1mem [16];
   assign l1r_data = l1mem[l1r_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) l1mem[i] <= 16'hA000 + DW'(i);
      end else if (l1w_valid && l1w_ready) begin
         l1mem[l1w_addr] <= l1w_data;
      end
   end

   // Reference model
   logic [EW-1:0] mq[$];
   logic [DW-1:0] ref_mem [16];
   bit            e_rsp_v = 1'b0;
   bit            e_rsp_f = 1'b0;
   logic [DW-1:0] e_rsp_d = '0;
   string         e_tag = "R7";
   bit            fence_done = 1'b0;
   bit            finished = 1'b0;
   int            checks = 0;
   int            fails = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // One clock: drive at the falling edge, check the outputs, advance the model
   task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input bit lv, input logic [AW-1:0] la,
                       input bit fv, input bit wr);
      bit            exp_st_rdy, ld_fire, hit;
      logic [DW-1:0] hd;
      @(negedge clk);
      st_valid = sv; st_addr = sa; st_data = sd;
      ld_valid = lv; ld_addr = la;
      fence_valid = fv; l1w_ready = wr;
      #1;
      exp_st_rdy = (mq.size() < DEPTH) && !fv;
      chk(st_ready === exp_st_rdy, fv ? "R9" : "R2", "st_ready", 32'(st_ready), 32'(exp_st_rdy));
      chk(ld_ready === !fv, "R9", "ld_ready", 32'(ld_ready), 32'(!fv));
      chk(fence_ready === (mq.size() == 0), "R9", "fence_ready",
          32'(fence_ready), 32'(mq.size() == 0));
      chk(l1w_valid === (mq.size() != 0), "R4", "l1w_valid",
          32'(l1w_valid), 32'(mq.size() != 0));
      if (mq.size() != 0)
         chk({l1w_addr, l1w_data} === mq[0], "R3", "l1w addr/data",
             32'({l1w_addr, l1w_data}), 32'(mq[0]));
      chk(ld_rsp_valid === e_rsp_v, "R7", "ld_rsp_valid", 32'(ld_rsp_valid), 32'(e_rsp_v));
      if (e_rsp_v) begin
         chk(ld_rsp_data === e_rsp_d, e_tag, "ld_rsp_data", 32'(ld_rsp_data), 32'(e_rsp_d));
         chk(ld_rsp_fwd === e_rsp_f, e_tag, "ld_rsp_fwd", 32'(ld_rsp_fwd), 32'(e_rsp_f));
      end
      fence_done = fv && (mq.size() == 0);

      // Load search against the entries present before this edge; last match is youngest
      ld_fire = lv && !fv;
      hit = 1'b0;
      hd  = '0;
      for (int k = 0; k < mq.size(); k++) begin
         if (mq[k][EW-1:DW] == la) begin
            hit = 1'b1;
            hd  = mq[k][DW-1:0];
         end
      end
      chk(l1r_en === (ld_fire && !hit), hit ? "R5" : "R6", "l1r_en",
          32'(l1r_en), 32'(ld_fire && !hit));
      if (ld_fire && !hit)
         chk(l1r_addr === la, "R6", "l1r_addr", 32'(l1r_addr), 32'(la));
      e_rsp_v = ld_fire;
      e_rsp_f = hit;
      e_rsp_d = hit ? hd : ref_mem[la];
      if (ld_fire && sv && exp_st_rdy && sa == la) e_tag = "R8";
      else                                         e_tag = hit ? "R5" : "R6";

      if (mq.size() != 0 && wr) begin
         ref_mem[mq[0][EW-1:DW]] = mq[0][DW-1:0];
         void'(mq.pop_front());
      end
      if (sv && exp_st_rdy) mq.push_back({sa, sd});
   endtask

   initial begin
      for (int i = 0; i < 16; i++) ref_mem[i] = 16'hA000 + DW'(i);
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      chk(l1w_valid === 1'b0, "R1", "l1w_valid", 32'(l1w_valid), 0);
      chk(fence_ready === 1'b1, "R1", "fence_ready", 32'(fence_ready), 1);
      chk(st_ready === 1'b1, "R1", "st_ready", 32'(st_ready), 1);
      chk(ld_rsp_valid === 1'b0, "R1", "ld_rsp_valid", 32'(ld_rsp_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: fill with L1 stalled; address 0 buffered twice
      for (int i = 0; i < 6; i++)
         step(1'b1, AW'(i % 3), DW'(16'h0100 + i), 1'b0, '0, 1'b0, 1'b0);
      // R5: youngest match, single match, then a miss (R6)
      step(1'b0, '0, '0, 1'b1, 4'h0, 1'b0, 1'b0);
      step(1'b0, '0, '0, 1'b1, 4'h1, 1'b0, 1'b0);
      step(1'b0, '0, '0, 1'b1, 4'h5, 1'b0, 1'b0);
      // R3/R4: drain with a toggling ready while loads probe
      for (int i = 0; i < 10; i++)
         step(1'b0, '0, '0, 1'b1, AW'(i % 4), 1'b0, i[0]);
      // R8: store and load to the same address in one cycle, then a hit
      step(1'b1, 4'h7, 16'hBEEF, 1'b1, 4'h7, 1'b0, 1'b0);
      step(1'b0, '0, '0, 1'b1, 4'h7, 1'b0, 1'b0);
      // R9: fence waits for drain while core ports are blocked
      for (int i = 0; i < 2; i++)
         step(1'b1, AW'(8 + i), DW'(16'h0200 + i), 1'b0, '0, 1'b0, 1'b0);
      repeat (3) step(1'b1, 4'h9, 16'h0333, 1'b1, 4'h9, 1'b1, 1'b0);
      fence_done = 1'b0;
      for (int n = 0; n < 12 && !fence_done; n++)
         step(1'b1, 4'h9, 16'h0444, 1'b1, 4'h9, 1'b1, 1'b1);
      chk(fence_done, "R9", "fence completion", 32'(fence_done), 1);

      // Random mix over a small address set
      begin
         bit hold_fence;
         hold_fence = 1'b0;
         for (int c = 0; c < 3000; c++) begin
            if (!hold_fence && ($urandom % 60) == 0) hold_fence = 1'b1;
            step(1'($urandom % 2), AW'($urandom % 8), DW'($urandom),
                 1'($urandom % 2), AW'($urandom % 8), hold_fence,
                 1'(($urandom % 4) != 0));
            if (hold_fence && fence_done) hold_fence = 1'b0;
         end
      end
      step(1'b0, '0, '0, 1'b0, '0, 1'b0, 1'b1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements) actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule